// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This unit sits in the second stage of a five-stage in-order pipeline. Fetch always assumes that control flow falls through, so it keeps fetching sequentially at PC+4 and loses no cycles while that guess holds. Each cycle the resolver looks at the instruction that is in decode. It compares the two forwarded register operands for equal and not-equal branches and forms the branch, jump or register target. In the same cycle it tells fetch to load that target instead of the sequential address.

When control flow is redirected, the one instruction that was fetched behind the branch or jump is wrong. The resolver raises a flush that turns the fetch/decode register into a no-op. It also keeps one bit of state, so the instruction in decode during the following cycle is ignored even if upstream did not clear it. A taken branch or any jump therefore costs exactly one slot. For the call-style jump it also reports a link write of the return address into the link register.

Top module: `branch_resolve`

## Requirements
- R1: The type code on `id_kind` is 0 for no control transfer, 1 for branch-if-equal, 2 for branch-if-not-equal, 3 for direct jump, 4 for jump-and-link, and 5 for register jump. Codes 0, 6 and 7 never raise `redirect`, `flush_if` or `link_we`.
- R2: For code 1, `redirect` is high exactly when `opnd_a` equals `opnd_b`. The target is `id_pc`+4 plus the sign-extended `id_field[15:0]` shifted left by two.
- R3: For code 2, `redirect` is high exactly when `opnd_a` differs from `opnd_b`, with the same target as R2.
- R4: For code 3, `redirect` is always high. The target is bits 31..28 of `id_pc`+4 concatenated with `id_field[25:0]` and two zero bits.
- R5: For code 4, the behaviour is that of R4. In addition, `link_we` is high, `link_idx` is 31 and `link_val` is `id_pc`+4. `link_we` is never high for any other code.
- R6: For code 5, `redirect` is always high and the target is `opnd_a` unchanged.
- R7: `flush_if` equals `redirect` in the same cycle, and both follow the inputs combinationally. A redirect therefore squashes exactly one fetched instruction.
- R8: In the cycle after a cycle with `redirect` high, the instruction in decode is ignored. `redirect`, `flush_if` and `link_we` stay low whatever its code.
- R9: Reset (active-low `rst_n`) clears the squash state, so the first instruction after reset is resolved normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_kind | input | 3 | Control-transfer type code of the decode instruction |
| id_pc | input | 32 | Address of the decode instruction |
| opnd_a | input | 32 | First register operand after forwarding |
| opnd_b | input | 32 | Second register operand after forwarding |
| id_field | input | 26 | Jump index; low 16 bits are the branch offset |
| redirect | output | 1 | Next-PC select: 1 loads `target` into fetch |
| target | output | 32 | Redirect address |
| flush_if | output | 1 | Clears the fetch/decode register to a no-op |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Return address to write |

## Verification
The only internal state is the squash bit. If it is wrong, the fault shows in the very next cycle in one of two ways: a lost redirect on an instruction that should have resolved, or a second redirect straight after a taken transfer. The bench runs random type codes and operands, with equal operands forced often, behind every kind of transfer. Every cycle it compares `redirect`, `flush_if`, `target` and the link outputs with a reference model that tracks the squash state itself. Errors in target arithmetic show at once on `target`, including negative offsets and the PC region bits of direct jumps.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_BEQ  = 3'd1;
    localparam logic [2:0] K_BNE  = 3'd2;
    localparam logic [2:0] K_JMP  = 3'd3;
    localparam logic [2:0] K_JAL  = 3'd4;
    localparam logic [2:0] K_JR   = 3'd5;

    typedef struct packed {
        logic squash;
    } res_state_t;
endpackage

// File: rtl/branch_resolve_cmp.sv
module branch_resolve_cmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            same
);
    logic [XLEN-1:0] diff;
    always_comb begin
        diff = a ^ b;
        same = ~|diff;
    end
endmodule

// File: rtl/branch_resolve_addr.sv
module branch_resolve_addr #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IDX_W-1:0] field,
    output logic [XLEN-1:0]  pc_next,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int HI_W  = XLEN - IDX_W - 2;

    logic [OFF_W-1:0] off;
    logic [XLEN-1:0]  off_sh;

    always_comb begin
        off     = field[OFF_W-1:0];
        off_sh  = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
        pc_next = pc + XLEN'(4);
        br_tgt  = pc_next + off_sh;
        jmp_tgt = {pc_next[XLEN-1 -: HI_W], field, 2'b00};
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        id_kind,
    input  logic [XLEN-1:0]   id_pc,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [IDX_W-1:0]  id_field,
    output logic              redirect,
    output logic [XLEN-1:0]   target,
    output logic              flush_if,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val
);
    res_state_t st_q, st_d;

    logic            same;
    logic [XLEN-1:0] pc_next, br_tgt, jmp_tgt;
    logic            take;
    logic            lnk;
    logic [XLEN-1:0] tgt;

    branch_resolve_cmp #(.XLEN(XLEN)) u_cmp (
        .a    (opnd_a),
        .b    (opnd_b),
        .same (same)
    );

    branch_resolve_addr #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .pc      (id_pc),
        .field   (id_field),
        .pc_next (pc_next),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        lnk  = 1'b0;
        tgt  = br_tgt;
        if (!st_q.squash) begin
            case (id_kind)
                K_BEQ: take = same;
                K_BNE: take = ~same;
                K_JMP: begin
                    take = 1'b1;
                    tgt  = jmp_tgt;
                end
                K_JAL: begin
                    take = 1'b1;
                    lnk  = 1'b1;
                    tgt  = jmp_tgt;
                end
                K_JR: begin
                    take = 1'b1;
                    tgt  = opnd_a;
                end
                default: ;
            endcase
        end
        st_d.squash = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redirect = take;
    assign flush_if = take;
    assign target   = tgt;
    assign link_we  = lnk;
    assign link_idx = RIDX_W'(LINK_REG);
    assign link_val = pc_next;
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
    parameter int XLEN   = 32,
    parameter int IDX_W  = 26,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        id_kind,
    input logic [XLEN-1:0]   id_pc,
    input logic [XLEN-1:0]   opnd_a,
    input logic [XLEN-1:0]   opnd_b,
    input logic              redirect,
    input logic [XLEN-1:0]   target,
    input logic              flush_if,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [XLEN-1:0]   link_val
);
    logic [XLEN-1:0] pc4;
    assign pc4 = id_pc + XLEN'(4);

    assert_idle_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 3'd0 || id_kind > 3'd5) |-> (!redirect && !flush_if && !link_we));

    assert_beq_unequal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind == 3'd1 && opnd_a != opnd_b) |-> !redirect);

    assert_jump_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && id_kind == 3'd3) |->
        (target[XLEN-1 -: 4] == pc4[XLEN-1 -: 4] && target[1:0] == 2'b00));

    assert_link_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (redirect && id_kind == 3'd4 && link_idx == RIDX_W'(31) && link_val == pc4));

    assert_flush_pairs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |-> redirect);

    assert_slot_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!redirect && !flush_if && !link_we));
endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .RIDX_W(RIDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_kind  (id_kind),
    .id_pc    (id_pc),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .redirect (redirect),
    .target   (target),
    .flush_if (flush_if),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val)
);

// File: tb/branch_resolve_bench.sv
`timescale 1ns/1ps
module branch_resolve_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  id_kind = 3'd0;
    logic [31:0] id_pc = 32'h0;
    logic [31:0] opnd_a = 32'h0;
    logic [31:0] opnd_b = 32'h0;
    logic [25:0] id_field = 26'h0;
    logic        redirect, flush_if, link_we;
    logic [31:0] target, link_val;
    logic [4:0]  link_idx;

    int total = 0;
    int bad = 0;
    logic exp_sq = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    branch_resolve u_branch_resolve (
        .clk(clk), .rst_n(rst_n), .id_kind(id_kind), .id_pc(id_pc),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .id_field(id_field),
        .redirect(redirect), .target(target), .flush_if(flush_if),
        .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
    );

    function automatic logic f_take(input logic sq, input logic [2:0] k,
                                    input logic [31:0] a, input logic [31:0] b);
        if (sq) return 1'b0;
        case (k)
            3'd1: return a == b;
            3'd2: return a != b;
            3'd3, 3'd4, 3'd5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] f_tgt(input logic [2:0] k, input logic [31:0] pc,
                                          input logic [31:0] a, input logic [25:0] f);
        logic [31:0] n;
        n = pc + 32'd4;
        case (k)
            3'd3, 3'd4: return {n[31:28], f, 2'b00};
            3'd5: return a;
            default: return n + ($signed({{16{f[15]}}, f[15:0]}) * 4);
        endcase
    endfunction

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [2:0] k, input logic [31:0] pc,
                        input logic [31:0] a, input logic [31:0] b, input logic [25:0] f);
        logic t;
        logic [31:0] tg;
        @(negedge clk);
        id_kind = k; id_pc = pc; opnd_a = a; opnd_b = b; id_field = f;
        #1;
        t = f_take(exp_sq, k, a, b);
        tg = f_tgt(k, pc, a, f);
        chk({req, " redirect"}, redirect === t, 32'(redirect), 32'(t));
        chk({req, " flush R7"}, flush_if === t, 32'(flush_if), 32'(t));
        chk({req, " link R5"}, link_we === (t && k == 3'd4), 32'(link_we), 32'(t && k == 3'd4));
        if (t) chk({req, " target"}, target === tg, target, tg);
        if (t && k == 3'd4) begin
            chk("R5 link_idx", link_idx === 5'd31, 32'(link_idx), 32'd31);
            chk("R5 link_val", link_val === pc + 32'd4, link_val, pc + 32'd4);
        end
        exp_sq = t;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] k;
        logic [31:0] a, b;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9 reset redirect", redirect === 1'b0, 32'(redirect), 32'd0);
        chk("R9 reset link", link_we === 1'b0, 32'(link_we), 32'd0);
        rst_n = 1'b1;
        // R9: first instruction after reset is resolved
        step("R9 first beq", 3'd1, 32'h0000_1000, 32'd7, 32'd7, 26'h0004);
        step("R8 slot after beq", 3'd3, 32'h0000_1004, 32'd0, 32'd0, 26'h123);
        step("R2 beq unequal", 3'd1, 32'h0000_2000, 32'd1, 32'd2, 26'h0010);
        step("R2 beq negative", 3'd1, 32'h0000_3000, 32'd9, 32'd9, 26'h0FFFC);
        step("R8 slot jal", 3'd4, 32'h0000_3004, 32'd0, 32'd0, 26'h1);
        step("R3 bne unequal", 3'd2, 32'h0000_4000, 32'd5, 32'd6, 26'h8000);
        step("R8 idle", 3'd0, 32'h0000_4004, 32'd0, 32'd0, 26'h0);
        step("R3 bne equal", 3'd2, 32'h0000_5000, 32'd3, 32'd3, 26'h0020);
        step("R4 jump region", 3'd3, 32'hEFFF_FFFC, 32'd0, 32'd0, 26'h3FFFFFF);
        step("R1 none", 3'd0, 32'h0000_6000, 32'd4, 32'd4, 26'h0);
        step("R5 jal", 3'd4, 32'h1234_5678, 32'd0, 32'd0, 26'h0ABCDEF);
        step("R1 code6", 3'd6, 32'h0000_7000, 32'd4, 32'd4, 26'h0);
        step("R1 code7", 3'd7, 32'h0000_7004, 32'd4, 32'd5, 26'h0);
        step("R6 jr", 3'd5, 32'h0000_8000, 32'hDEAD_BEE0, 32'd0, 26'h0);
        // R9: reset while squash pending
        step("R6 jr again", 3'd5, 32'h0000_9000, 32'h0000_0400, 32'd0, 26'h0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        exp_sq = 1'b0;
        step("R9 after reset jr", 3'd5, 32'h0000_A000, 32'h0000_0800, 32'd0, 26'h0);
        for (int i = 0; i < 3000; i++) begin
            k = 3'($urandom_range(0, 7));
            a = $urandom;
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            step("R2 R3 R4 R5 R6 R8 random", k, {$urandom} & 32'hFFFF_FFFC, a, b, 26'($urandom));
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule